// File: doc/BRIEF.md
# Frame Status Queue with Halt Resume

This block keeps one small status record per received frame for a framed serial receiver. When the receive path finishes a frame, it pushes one record holding the frame length and four error flags: receive overrun during the frame, frame too long, abort seen, and CRC failure. Records leave the queue in arrival order, so the record at the head always describes the frame that is next in the receive data FIFO.

Software reads the head record through a synchronous 8-bit register read port. The two length bytes can be read as often as needed and have no side effect. Software reads them first, then reads the line-status byte, which returns the flags and removes the record. A second, independent part keeps one halt flag per direction. A transmit underrun or a receive overrun sets the halt flag for that direction. A read of a register that holds no storage of its own clears both halt flags.

Top module: `frame_status_queue`

## Requirements
- R1: After reset the queue is empty, both halt outputs are low, the overflow bit is 0, and a status read returns 0x00.
- R2: Each accepted push stores one record at the tail of the queue. Records come out in push order, one per status read.
- R3: A read of address 0 returns length bits 7:0 of the head record. A read of address 1 returns length bits 11:8 in data bits 3:0, with bits 7:4 zero. Neither read removes the record.
- R4: A read of address 2 returns the head flags with overrun in bit 4, too-long in bit 3, abort in bit 2 and CRC in bit 1. Bits 7:5 and bit 0 read as zero. The read removes exactly one record.
- R5: When the queue is empty, reads of addresses 0, 1 and 2 return 0x00 and remove nothing. A record pushed afterwards is the next one read.
- R6: Read data is valid in the cycle after the strobe cycle. In the cycle after a cycle with no strobe, the data is 0x00. Each strobe cycle causes at most one side effect.
- R7: A push while the queue holds DEPTH records and no record is removed in the same cycle is dropped. It sets a sticky overflow bit, read at address 4 bit 0 (other bits zero), which only reset clears. The stored records are not changed.
- R8: A push in the same cycle as a status read on a full queue is accepted, and no overflow is recorded.
- R9: A pulse on tx_underrun_i raises tx_halt_o, and a pulse on rx_overrun_i raises rx_halt_o, from the next cycle. Each halt stays high until a resume read.
- R10: A read of address 3 returns 0x00 and clears both halt outputs from the cycle after the strobe. If a halt event arrives in the same cycle as the resume read, that direction stays halted.
- R11: Reads of addresses 5 to 7 return 0x00 and change neither the queue nor the halt flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | End-of-frame strobe: push one record |
| push_len_i | input | LEN_W (12) | Frame length to store |
| push_ovr_i | input | 1 | Overrun occurred during this frame |
| push_long_i | input | 1 | Frame exceeded the allowed length |
| push_abort_i | input | 1 | Abort pattern seen in this frame |
| push_crc_i | input | 1 | CRC check failed for this frame |
| tx_underrun_i | input | 1 | Transmit underrun event |
| rx_overrun_i | input | 1 | Receive overrun event |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe |
| tx_halt_o | output | 1 | Transmit direction halted |
| rx_halt_o | output | 1 | Receive direction halted |

## Verification
A wrong read pointer shows at the ports in the first status or length read after the fault: software gets a record that is out of order or repeated. A pointer that moves on a length read or on an empty read shows as a skipped record on the next status read. A wrong occupancy count shows when the queue fills: a push is dropped too early, or an entry is overwritten and a stale record comes out. A wrong halt flag shows on the halt outputs one cycle after the event or after the resume strobe.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEN_LO = 3'd0,
        REG_LEN_HI = 3'd1,
        REG_LSTAT  = 3'd2,
        REG_RESUME = 3'd3,
        REG_QINFO  = 3'd4
    } fsq_reg_e;

    typedef struct packed {
        logic ovr;
        logic too_long;
        logic abort;
        logic crc;
    } fsq_flags_t;

    localparam int FLAGS_W = $bits(fsq_flags_t);

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int N_DIR  = 2;

    function automatic logic [DATA_W-1:0] status_byte(input fsq_flags_t f);
        return {3'b000, f.ovr, f.too_long, f.abort, f.crc, 1'b0};
    endfunction

endpackage

// File: rtl/fsq_store.sv
module fsq_store
    import fsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [LEN_W-1:0] push_len_i,
    input  fsq_flags_t       push_flags_i,
    input  logic             pop_i,
    output logic [LEN_W-1:0] head_len_o,
    output fsq_flags_t       head_flags_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [LEN_W-1:0] len_mem  [DEPTH];
    fsq_flags_t       flag_mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             ovf_q;
    logic             do_push, do_pop;

    assign empty_o = (count == '0);
    assign full_o  = (count == FULL_CNT);
    assign do_pop  = pop_i && !empty_o;
    assign do_push = push_i && (!full_o || do_pop);

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            len_mem[wr_ptr]  <= push_len_i;
            flag_mem[wr_ptr] <= push_flags_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push_i && !do_push) ovf_q <= 1'b1;
        end
    end

    assign head_len_o   = len_mem[rd_ptr];
    assign head_flags_o = flag_mem[rd_ptr];
    assign ovf_o        = ovf_q;

    // R5: the read decode never asks for a pop while the queue is empty
    a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);
    // R7: the overflow bit stays set until reset
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);
    // R2: a lone push into a queue with room grows it by one
    a_r2_count_grow: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full_o && !pop_i) |=> (count == $past(count) + 1'b1));
    // R8: push and pop together on a full queue keep it full
    a_r8_full_swap: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && full_o) |=> full_o);

endmodule

// File: rtl/fsq_regrd.sv
module fsq_regrd
    import fsq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [LEN_W-1:0]  head_len_i,
    input  fsq_flags_t        head_flags_i,
    input  logic              empty_i,
    input  logic              ovf_i,
    output logic              pop_o,
    output logic              resume_o,
    output logic [DATA_W-1:0] rd_data_o
);
    fsq_reg_e          sel;
    logic [DATA_W-1:0] len_lo, len_hi, rd_next, rd_q;

    assign sel    = fsq_reg_e'(rd_addr_i);
    assign len_lo = empty_i ? '0 : DATA_W'(head_len_i);
    assign len_hi = empty_i ? '0 : DATA_W'(head_len_i >> DATA_W);

    always_comb begin
        rd_next = '0;
        if (rd_en_i) begin
            case (sel)
                REG_LEN_LO: rd_next = len_lo;
                REG_LEN_HI: rd_next = len_hi;
                REG_LSTAT:  rd_next = empty_i ? '0 : status_byte(head_flags_i);
                REG_QINFO:  rd_next = {{(DATA_W-1){1'b0}}, ovf_i};
                default:    rd_next = '0;
            endcase
        end
    end

    assign pop_o    = rd_en_i && (sel == REG_LSTAT) && !empty_i;
    assign resume_o = rd_en_i && (sel == REG_RESUME);

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_next;
    end

    assign rd_data_o = rd_q;

    // R10: the resume register always reads as zero
    a_r10_resume_zero: assert property (@(posedge clk) disable iff (rst)
        resume_o |=> (rd_data_o == '0));
    // R6: no strobe, no data
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> (rd_data_o == '0));
    // R4: reserved status bits stay zero
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && sel == REG_LSTAT) |=> (rd_data_o[7:5] == 3'b000 && rd_data_o[0] == 1'b0));

endmodule

// File: rtl/fsq_halt.sv
module fsq_halt
    import fsq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DIR-1:0] event_i,
    input  logic             resume_i,
    output logic [N_DIR-1:0] halt_o
);
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        logic halt_q;

        always_ff @(posedge clk) begin
            if (rst)              halt_q <= 1'b0;
            else if (event_i[d])  halt_q <= 1'b1;
            else if (resume_i)    halt_q <= 1'b0;
        end

        assign halt_o[d] = halt_q;

        // R9: an event halts its direction on the next cycle
        a_r9_event_halts: assert property (@(posedge clk) disable iff (rst)
            event_i[d] |=> halt_o[d]);
        // R10: resume without a new event releases the direction
        a_r10_resume_clears: assert property (@(posedge clk) disable iff (rst)
            (resume_i && !event_i[d]) |=> !halt_o[d]);
        // R9: a halt only drops after a resume
        a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
            (halt_o[d] && !resume_i) |=> halt_o[d]);
    end

endmodule

// File: rtl/frame_status_queue.sv
module frame_status_queue
    import fsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [LEN_W-1:0]  push_len_i,
    input  logic              push_ovr_i,
    input  logic              push_long_i,
    input  logic              push_abort_i,
    input  logic              push_crc_i,
    input  logic              tx_underrun_i,
    input  logic              rx_overrun_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              tx_halt_o,
    output logic              rx_halt_o
);
    fsq_flags_t       in_flags, head_flags;
    logic [LEN_W-1:0] head_len;
    logic             empty, full, ovf, pop, resume;
    logic [N_DIR-1:0] dir_event, dir_halt;

    assign in_flags = '{ovr: push_ovr_i, too_long: push_long_i,
                        abort: push_abort_i, crc: push_crc_i};

    fsq_store #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .push_i       (push_i),
        .push_len_i   (push_len_i),
        .push_flags_i (in_flags),
        .pop_i        (pop),
        .head_len_o   (head_len),
        .head_flags_o (head_flags),
        .empty_o      (empty),
        .full_o       (full),
        .ovf_o        (ovf)
    );

    fsq_regrd #(.LEN_W(LEN_W)) u_regrd (
        .clk          (clk),
        .rst          (rst),
        .rd_en_i      (rd_en_i),
        .rd_addr_i    (rd_addr_i),
        .head_len_i   (head_len),
        .head_flags_i (head_flags),
        .empty_i      (empty),
        .ovf_i        (ovf),
        .pop_o        (pop),
        .resume_o     (resume),
        .rd_data_o    (rd_data_o)
    );

    assign dir_event[DIR_TX] = tx_underrun_i;
    assign dir_event[DIR_RX] = rx_overrun_i;

    fsq_halt u_halt (
        .clk      (clk),
        .rst      (rst),
        .event_i  (dir_event),
        .resume_i (resume),
        .halt_o   (dir_halt)
    );

    assign tx_halt_o = dir_halt[DIR_TX];
    assign rx_halt_o = dir_halt[DIR_RX];

    // R7: a full queue stays full while nothing is removed
    a_r7_full_kept: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

endmodule

// File: tb/frame_status_queue_tb.sv
module frame_status_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int LEN_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push_i = 0, push_ovr_i = 0, push_long_i = 0, push_abort_i = 0, push_crc_i = 0;
    logic [LEN_W-1:0] push_len_i = '0;
    logic tx_underrun_i = 0, rx_overrun_i = 0, rd_en_i = 0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic tx_halt_o, rx_halt_o;

    frame_status_queue #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .push_i(push_i), .push_len_i(push_len_i),
        .push_ovr_i(push_ovr_i), .push_long_i(push_long_i),
        .push_abort_i(push_abort_i), .push_crc_i(push_crc_i),
        .tx_underrun_i(tx_underrun_i), .rx_overrun_i(rx_overrun_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .tx_halt_o(tx_halt_o), .rx_halt_o(rx_halt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    int m_len [0:1023];
    int m_fl  [0:1023];
    int m_head = 0;
    int m_tail = 0;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        m_head = 0;
        m_tail = 0;
    endtask

    task automatic drive_push(input int len, input int fl);
        push_i       = 1;
        push_len_i   = LEN_W'(len);
        push_ovr_i   = fl[3];
        push_long_i  = fl[2];
        push_abort_i = fl[1];
        push_crc_i   = fl[0];
    endtask

    // pushes and records in the model only if the queue has room
    task automatic push(input int len, input int fl);
        @(negedge clk);
        drive_push(len, fl);
        if (m_tail - m_head < DEPTH) begin
            m_len[m_tail] = len;
            m_fl[m_tail]  = fl;
            m_tail++;
        end
        @(negedge clk);
        push_i = 0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        rd_en_i = 1;
        rd_addr_i = 3'(addr);
        @(negedge clk);
        rd_en_i = 0;
        data = int'(rd_data_o);
    endtask

    task automatic read_head_check(input string tag);
        int d;
        int l, f;
        l = m_len[m_head];
        f = m_fl[m_head];
        rd(0, d); check({tag, " R3 len lo"}, d, l & 8'hFF);
        rd(1, d); check({tag, " R3 len hi"}, d, (l >> 8) & 4'hF);
        rd(0, d); check({tag, " R3 len lo reread"}, d, l & 8'hFF);
        rd(2, d); check({tag, " R4 status"}, d, f * 2);
        m_head++;
    endtask

    initial begin
        int d;
        int hold_l, hold_f;

        do_reset();
        // R1: reset state
        check("R1 tx_halt", int'(tx_halt_o), 0);
        check("R1 rx_halt", int'(rx_halt_o), 0);
        rd(4, d); check("R1 overflow bit", d, 0);
        rd(2, d); check("R1 status empty", d, 0);

        // R2 R3 R4: every fill level, arithmetic patterns
        for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++)
                push((n * 613 + k * 1237 + 5) & 12'hFFF, (k * 5 + n) & 4'hF);
            for (int k = 0; k < n; k++)
                read_head_check("R2 fill");
            // R5: empty reads
            rd(2, d); check("R5 status empty", d, 0);
            rd(0, d); check("R5 len lo empty", d, 0);
            rd(1, d); check("R5 len hi empty", d, 0);
        end

        // R5: every flag code through an interleaved push/read pattern
        for (int f = 0; f < 16; f++) begin
            push(f * 257, f);
            push(4095 - f, 15 - f);
            read_head_check("R2 interleave");
            read_head_check("R2 interleave");
        end
        rd(2, d); check("R5 empty again", d, 0);
        push(12'hABC, 4'h9);
        read_head_check("R5 after empty read");

        // R6: data valid the cycle after the strobe, zero after an idle cycle
        push(12'h3C5, 4'h6);
        @(negedge clk);
        rd_en_i = 1; rd_addr_i = 3'd0;
        @(negedge clk);
        rd_en_i = 0;
        check("R6 data next cycle", int'(rd_data_o), 8'hC5);
        @(negedge clk);
        check("R6 idle data zero", int'(rd_data_o), 0);
        // R6: strobe held for two cycles on status gives two pops
        push(12'h111, 4'h1);
        @(negedge clk);
        rd_en_i = 1; rd_addr_i = 3'd2;
        @(negedge clk);
        check("R6 first strobe status", int'(rd_data_o), 8'h0C);
        @(negedge clk);
        rd_en_i = 0;
        check("R6 second strobe status", int'(rd_data_o), 8'h02);
        m_head += 2;
        rd(2, d); check("R6 queue empty after two pops", d, 0);

        // R11: unmapped addresses
        push(12'h5A5, 4'hA);
        tx_underrun_i = 0;
        for (int a = 5; a < 8; a++) begin
            rd(a, d); check("R11 unmapped reads zero", d, 0);
        end
        read_head_check("R11 head unchanged");

        // R7: overflow
        do_reset();
        for (int k = 0; k < DEPTH + 3; k++) push(100 + k * 7, k & 4'hF);
        rd(4, d); check("R7 overflow set", d, 1);
        for (int k = 0; k < DEPTH; k++) read_head_check("R7 kept order");
        rd(2, d); check("R7 dropped pushes absent", d, 0);
        rd(4, d); check("R7 overflow sticky", d, 1);

        // R8: push and pop same cycle on full queue
        do_reset();
        for (int k = 0; k < DEPTH; k++) push(200 + k * 11, (k + 3) & 4'hF);
        hold_l = 12'h7E1; hold_f = 4'hD;
        @(negedge clk);
        drive_push(hold_l, hold_f);
        rd_en_i = 1; rd_addr_i = 3'd2;
        @(negedge clk);
        push_i = 0; rd_en_i = 0;
        check("R8 status of popped entry", int'(rd_data_o), m_fl[m_head] * 2);
        m_head++;
        m_len[m_tail] = hold_l; m_fl[m_tail] = hold_f; m_tail++;
        rd(4, d); check("R8 no overflow", d, 0);
        for (int k = 0; k < DEPTH; k++) read_head_check("R8 order");

        // R9 R10: all event combinations
        for (int c = 1; c < 4; c++) begin
            @(negedge clk);
            tx_underrun_i = c[0]; rx_overrun_i = c[1];
            @(negedge clk);
            tx_underrun_i = 0; rx_overrun_i = 0;
            check("R9 tx halt set", int'(tx_halt_o), c & 1);
            check("R9 rx halt set", int'(rx_halt_o), (c >> 1) & 1);
            repeat (3) @(negedge clk);
            check("R9 tx halt holds", int'(tx_halt_o), c & 1);
            check("R9 rx halt holds", int'(rx_halt_o), (c >> 1) & 1);
            rd_en_i = 1; rd_addr_i = 3'd3;
            check("R10 halt before resume edge", int'(tx_halt_o | rx_halt_o), 1);
            @(negedge clk);
            rd_en_i = 0;
            check("R10 resume reads zero", int'(rd_data_o), 0);
            check("R10 tx cleared", int'(tx_halt_o), 0);
            check("R10 rx cleared", int'(rx_halt_o), 0);
        end
        // R10: event in same cycle as resume wins
        @(negedge clk);
        rx_overrun_i = 1;
        @(negedge clk);
        rx_overrun_i = 0; tx_underrun_i = 1;
        rd_en_i = 1; rd_addr_i = 3'd3;
        @(negedge clk);
        tx_underrun_i = 0; rd_en_i = 0;
        check("R10 concurrent tx event stays", int'(tx_halt_o), 1);
        check("R10 rx cleared by resume", int'(rx_halt_o), 0);
        // R11: unmapped read does not clear halt
        rd(6, d);
        check("R11 halt untouched", int'(tx_halt_o), 1);
        rd(3, d);
        check("R10 final clear", int'(tx_halt_o), 0);

        finish_run();
    end
endmodule